// File: doc/BRIEF.md
# Page Frame Replacement Controller

This block keeps track of which virtual page sits in each of a small set of physical frames. A client presents one page reference per cycle, qualified by a valid strobe. For every accepted reference the block reports three things. It says whether the page was already resident (a hit) or missing (a fault). It gives the frame that now holds the page. On a fault that forced a replacement, it also gives the page that was thrown out. The block moves no page data. The client uses the report to start the actual transfer.

The rule for choosing a victim is picked per reference by a 2-bit policy input. The choices are: oldest-loaded first, newest-loaded first, least recently referenced, or a pseudo-random frame. A missing page always takes an empty frame while one exists, so a replacement happens only once every frame is occupied. Three running counters (references, hits, faults) give hit and miss ratios. A dedicated clear input zeroes the counters without disturbing the frame contents.

Top module: `page_frame_ctrl`

## Requirements
- R1: Each reference with `ref_valid` high produces exactly one report on the following clock edge, with `res_valid` high for that one cycle. `res_hit` is 1 when the page matched an occupied frame and 0 otherwise. On a hit, `res_frame` is the matching frame and nothing is evicted.
- R2: A fault while at least one frame is empty places the page in the lowest-numbered empty frame, with `res_evict_valid` low. Frames are never emptied except by reset.
- R3: With `policy` = 0 (oldest-loaded), a fault on a full table replaces the frame whose page was loaded earliest. Hits do not alter this order.
- R4: With `policy` = 1 (newest-loaded), a fault on a full table replaces the frame loaded most recently. From then on, that same frame is reused for every following fault, and hits do not alter the order.
- R5: With `policy` = 2 (least recent), a fault on a full table replaces the frame whose page was last referenced longest ago. Both hits and loads count as references.
- R6: With `policy` = 3 (random), a fault on a full table replaces frame S mod NUM_FRAMES. S is a 16-bit shift register: it resets to 0xACE1, and it advances on every accepted reference to {S[14:0], S[15]^S[13]^S[12]^S[10]}, after its current value has been used.
- R7: Each accepted reference adds one to `ref_count` and one to either `hit_count` or `fault_count`, visible on the same edge as its report.
- R8: `cnt_clr` high zeroes all three counters on the next edge and takes priority over a reference in the same cycle. It leaves frame contents unchanged.
- R9: Reset empties every frame, zeroes all counters and outputs, and reloads the random register seed.
- R10: With 3 frames starting empty, the references 4,7,6,1,7,6,1,2,7,2 give 6 faults and 4 hits under policy 0. They also give 6 faults under policy 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_clr | input | 1 | Zero the three statistics counters |
| policy | input | 2 | Victim rule: 0 oldest-loaded, 1 newest-loaded, 2 least recent, 3 random |
| ref_valid | input | 1 | A page reference is presented this cycle |
| ref_page | input | PAGE_W | Virtual page number referenced |
| res_valid | output | 1 | A report is present this cycle |
| res_hit | output | 1 | The reported reference was resident |
| res_frame | output | IDX_W | Frame holding the referenced page |
| res_evict_valid | output | 1 | A resident page was replaced |
| res_evict_page | output | PAGE_W | Page replaced (zero when none) |
| ref_count | output | CNT_W | References since reset or clear |
| hit_count | output | CNT_W | Hits since reset or clear |
| fault_count | output | CNT_W | Faults since reset or clear |

## Verification
The lookup, the victim choice and the table update all finish inside the reference cycle. The report and the three counters are therefore due on the first rising edge after the cycle in which `ref_valid` is high. The bench drives each reference on a falling edge, and it reads the report and counters on the next falling edge, half a period after that rising edge. It then drops `ref_valid`, so each report belongs to exactly one reference. A counter clear is read the same way, one edge after the pulse. To predict the random victim, the bench models the shift register independently and steps it once per reference it issues.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic [1:0] {
    POL_OLDEST = 2'd0,
    POL_NEWEST = 2'd1,
    POL_LRU    = 2'd2,
    POL_RAND   = 2'd3
  } pfr_policy_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // One step of the victim-selection shift register.
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Width of a frame index for n frames.
  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pfr_tag_store.sv
module pfr_tag_store #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 16,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAGE_W-1:0]     lookup_page,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [PAGE_W-1:0]     wr_page,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [PAGE_W-1:0]     rd_page,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx,
  output logic                  all_full,
  output logic [IDX_W-1:0]      free_idx,
  output logic [NUM_FRAMES-1:0] valid_vec
);

  logic [PAGE_W-1:0]     tag_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] vld_q;
  logic [NUM_FRAMES-1:0] match;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_page;
      end
    end
    assign match[g] = vld_q[g] && (tag_q[g] == lookup_page);
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    all_full = &vld_q;
    rd_page  = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld_q[i]) free_idx = IDX_W'(i);
      if (rd_idx == IDX_W'(i)) rd_page = tag_q[i];
    end
  end

  assign valid_vec = vld_q;

endmodule

// File: rtl/pfr_rank_tracker.sv
// Move-to-front ordering: rank 0 is the most recently touched frame,
// rank NUM_FRAMES-1 the one touched longest ago.
module pfr_rank_tracker #(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] newest_idx,
  output logic [IDX_W-1:0] oldest_idx
);

  logic [IDX_W-1:0] rank_q [NUM_FRAMES];
  logic [IDX_W-1:0] touched_rank;

  always_comb begin
    touched_rank = '0;
    newest_idx   = '0;
    oldest_idx   = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (touch_idx == IDX_W'(i)) touched_rank = rank_q[i];
      if (rank_q[i] == '0) newest_idx = IDX_W'(i);
      if (rank_q[i] == IDX_W'(NUM_FRAMES - 1)) oldest_idx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[g] <= IDX_W'(g);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(g))
          rank_q[g] <= '0;
        else if (rank_q[g] < touched_rank)
          rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfr_lfsr.sv
module pfr_lfsr (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  output logic [pfr_pkg::LFSR_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= pfr_pkg::LFSR_SEED;
    else if (step) state <= pfr_pkg::lfsr_advance(state);
  end

endmodule

// File: rtl/pfr_counters.sv
module pfr_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_ref,
  input  logic             inc_hit,
  input  logic             inc_fault,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] fault_count
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ref_count   <= '0;
      hit_count   <= '0;
      fault_count <= '0;
    end else begin
      if (inc_ref)   ref_count   <= ref_count + 1'b1;
      if (inc_hit)   hit_count   <= hit_count + 1'b1;
      if (inc_fault) fault_count <= fault_count + 1'b1;
    end
  end

endmodule

// File: rtl/page_frame_ctrl.sv
module page_frame_ctrl #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 16,
  parameter int CNT_W      = 32,
  localparam int IDX_W     = pfr_pkg::idx_width(NUM_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clr,
  input  logic [1:0]        policy,
  input  logic              ref_valid,
  input  logic [PAGE_W-1:0] ref_page,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_frame,
  output logic              res_evict_valid,
  output logic [PAGE_W-1:0] res_evict_page,
  output logic [CNT_W-1:0]  ref_count,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  fault_count
);
  import pfr_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic                  ref_hit;
  logic                  ref_fault;
  logic                  all_full;
  logic                  need_evict;
  logic [NUM_FRAMES-1:0] frame_vld;
  logic [IDX_W-1:0]      hit_idx;
  logic [IDX_W-1:0]      free_idx;
  logic [IDX_W-1:0]      victim_idx;
  logic [IDX_W-1:0]      target_idx;
  logic [IDX_W-1:0]      use_idx;
  logic [PAGE_W-1:0]     victim_page;
  logic                  lookup_hit;

  logic [IDX_W-1:0]      load_newest, load_oldest;
  logic [IDX_W-1:0]      use_newest,  use_oldest;
  logic [IDX_W-1:0]      rand_idx;
  logic [LFSR_W-1:0]     lfsr_q;
  pfr_policy_e           pol;

  assign pol = pfr_policy_e'(policy);

  pfr_tag_store #(
    .NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lookup_page(ref_page),
    .wr_en(ref_fault), .wr_idx(target_idx), .wr_page(ref_page),
    .rd_idx(victim_idx), .rd_page(victim_page),
    .hit(lookup_hit), .hit_idx(hit_idx),
    .all_full(all_full), .free_idx(free_idx),
    .valid_vec(frame_vld)
  );

  // Load order: touched only when a page is brought in.
  pfr_rank_tracker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_load_order (
    .clk(clk), .rst_n(rst_n),
    .touch_en(ref_fault), .touch_idx(target_idx),
    .newest_idx(load_newest), .oldest_idx(load_oldest)
  );

  // Use order: touched by every reference.
  pfr_rank_tracker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_use_order (
    .clk(clk), .rst_n(rst_n),
    .touch_en(ref_valid), .touch_idx(use_idx),
    .newest_idx(use_newest), .oldest_idx(use_oldest)
  );

  pfr_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(ref_valid), .state(lfsr_q)
  );

  pfr_counters #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .inc_ref(ref_valid), .inc_hit(ref_hit), .inc_fault(ref_fault),
    .ref_count(ref_count), .hit_count(hit_count), .fault_count(fault_count)
  );

  assign ref_hit    = ref_valid && lookup_hit;
  assign ref_fault  = ref_valid && !lookup_hit;
  assign need_evict = ref_fault && all_full;
  assign rand_idx   = IDX_W'(lfsr_q % LFSR_W'(NUM_FRAMES));

  // The unused newest-by-use index is kept for symmetry of the trackers.
  logic unused_ok;
  assign unused_ok = ^use_newest;

  always_comb begin
    unique case (pol)
      POL_OLDEST: victim_idx = load_oldest;
      POL_NEWEST: victim_idx = load_newest;
      POL_LRU:    victim_idx = use_oldest;
      default:    victim_idx = rand_idx;
    endcase
  end

  assign target_idx = all_full ? victim_idx : free_idx;
  assign use_idx    = lookup_hit ? hit_idx : target_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid       <= 1'b0;
      res_hit         <= 1'b0;
      res_frame       <= '0;
      res_evict_valid <= 1'b0;
      res_evict_page  <= '0;
    end else begin
      res_valid       <= ref_valid;
      res_hit         <= ref_hit;
      res_frame       <= ref_valid ? use_idx : '0;
      res_evict_valid <= need_evict;
      res_evict_page  <= need_evict ? victim_page : '0;
    end
  end

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int NUM_FRAMES = 4,
  parameter int CNT_W      = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ref_valid,
  input logic                  res_valid,
  input logic                  res_hit,
  input logic                  res_evict_valid,
  input logic [CNT_W-1:0]      ref_count,
  input logic [CNT_W-1:0]      hit_count,
  input logic [CNT_W-1:0]      fault_count,
  input logic                  all_full,
  input logic [NUM_FRAMES-1:0] frame_vld
);

  p_report_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> res_valid);

  p_no_spurious_report_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !res_valid);

  p_hit_never_evicts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> !res_evict_valid);

  p_evict_only_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_evict_valid |-> $past(all_full));

  p_frames_never_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(frame_vld) & ~frame_vld) == '0));

  p_counts_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_count == hit_count + fault_count);

endmodule

bind page_frame_ctrl pfr_checker #(
  .NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W)
) u_pfr_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid),
  .res_valid(res_valid), .res_hit(res_hit), .res_evict_valid(res_evict_valid),
  .ref_count(ref_count), .hit_count(hit_count), .fault_count(fault_count),
  .all_full(all_full), .frame_vld(frame_vld)
);

// File: tb/tb_page_frame_ctrl.sv
module tb_page_frame_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NF         = 3;
  localparam int PW         = 16;
  localparam int CW         = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_clr = 1'b0;
  logic [1:0]    policy = 2'd0;
  logic          ref_valid = 1'b0;
  logic [PW-1:0] ref_page = '0;
  logic          res_valid, res_hit, res_evict_valid;
  logic [1:0]    res_frame;
  logic [PW-1:0] res_evict_page;
  logic [CW-1:0] ref_count, hit_count, fault_count;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_lfsr;
  logic [PW-1:0] m_tag [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_frame_ctrl #(.NUM_FRAMES(NF), .PAGE_W(PW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .policy(policy),
    .ref_valid(ref_valid), .ref_page(ref_page),
    .res_valid(res_valid), .res_hit(res_hit), .res_frame(res_frame),
    .res_evict_valid(res_evict_valid), .res_evict_page(res_evict_page),
    .ref_count(ref_count), .hit_count(hit_count), .fault_count(fault_count)
  );

  // Independent model of the random register: taps 16,14,13,11 counted from 1.
  function automatic logic [15:0] model_step(input logic [15:0] s);
    logic fb;
    fb = ((s >> 15) & 1) ^ ((s >> 13) & 1) ^ ((s >> 12) & 1) ^ ((s >> 10) & 1);
    return (s << 1) | {15'd0, fb};
  endfunction

  task automatic report(input bit ok, input string rq, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", rq, what);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_valid = 1'b0; cnt_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_lfsr = 16'hACE1;
  endtask

  // Issue one reference; its report is due on the following rising edge.
  task automatic do_ref(input logic [PW-1:0] pg, input bit eh, input int ef,
                        input bit ee, input logic [PW-1:0] ep, input string rq);
    @(negedge clk);
    ref_valid = 1'b1; ref_page = pg;
    @(negedge clk);
    ref_valid = 1'b0;
    m_lfsr = model_step(m_lfsr);
    report(res_valid && res_hit == eh && int'(res_frame) == ef &&
           res_evict_valid == ee && res_evict_page == (ee ? ep : '0), rq,
           $sformatf("page %0d got v=%0b hit=%0b frame=%0d ev=%0b evp=%0d exp hit=%0b frame=%0d ev=%0b evp=%0d",
                     pg, res_valid, res_hit, res_frame, res_evict_valid, res_evict_page,
                     eh, ef, ee, ee ? ep : 16'd0));
  endtask

  task automatic check_counts(input int r, input int h, input int f, input string rq);
    report(ref_count == CW'(r) && hit_count == CW'(h) && fault_count == CW'(f), rq,
           $sformatf("counts got %0d/%0d/%0d exp %0d/%0d/%0d",
                     ref_count, hit_count, fault_count, r, h, f));
  endtask

  task automatic t_reset();
    do_reset();
    report(!res_valid && !res_hit && !res_evict_valid, "R9",
           $sformatf("outputs after reset got v=%0b h=%0b e=%0b exp 0", res_valid, res_hit, res_evict_valid));
    check_counts(0, 0, 0, "R9");
    do_ref(16'd5, 0, 0, 0, 0, "R9");
    do_reset();
    do_ref(16'd5, 0, 0, 0, 0, "R9");   // page 5 no longer resident
    check_counts(1, 0, 1, "R9");
  endtask

  task automatic t_idle();
    do_reset();
    do_ref(16'd9, 0, 0, 0, 0, "R1");
    @(negedge clk);
    report(!res_valid, "R1", $sformatf("report after idle cycle got %0b exp 0", res_valid));
    do_ref(16'd9, 1, 0, 0, 0, "R1");
  endtask

  task automatic t_canonical(input logic [1:0] pol, input string rq);
    do_reset();
    policy = pol;
    do_ref(16'd4, 0, 0, 0, 0, "R2");
    do_ref(16'd7, 0, 1, 0, 0, "R2");
    do_ref(16'd6, 0, 2, 0, 0, "R2");
    do_ref(16'd1, 0, 0, 1, 16'd4, rq);
    do_ref(16'd7, 1, 1, 0, 0, rq);
    do_ref(16'd6, 1, 2, 0, 0, rq);
    do_ref(16'd1, 1, 0, 0, 0, rq);
    do_ref(16'd2, 0, 1, 1, 16'd7, rq);
    do_ref(16'd7, 0, 2, 1, 16'd6, rq);
    do_ref(16'd2, 1, 1, 0, 0, rq);
    check_counts(10, 4, 6, "R10");
    check_counts(10, 4, 6, "R7");
  endtask

  task automatic t_fifo_hit();
    do_reset();
    policy = 2'd0;
    do_ref(16'd1, 0, 0, 0, 0, "R2");
    do_ref(16'd2, 0, 1, 0, 0, "R2");
    do_ref(16'd3, 0, 2, 0, 0, "R2");
    do_ref(16'd1, 1, 0, 0, 0, "R3");
    do_ref(16'd4, 0, 0, 1, 16'd1, "R3");   // hit did not protect page 1
  endtask

  task automatic t_lru_hit();
    do_reset();
    policy = 2'd2;
    do_ref(16'd1, 0, 0, 0, 0, "R5");
    do_ref(16'd2, 0, 1, 0, 0, "R5");
    do_ref(16'd3, 0, 2, 0, 0, "R5");
    do_ref(16'd1, 1, 0, 0, 0, "R5");
    do_ref(16'd4, 0, 1, 1, 16'd2, "R5");
    do_ref(16'd5, 0, 2, 1, 16'd3, "R5");
  endtask

  task automatic t_lifo();
    do_reset();
    policy = 2'd1;
    do_ref(16'd1, 0, 0, 0, 0, "R4");
    do_ref(16'd2, 0, 1, 0, 0, "R4");
    do_ref(16'd3, 0, 2, 0, 0, "R4");
    do_ref(16'd4, 0, 2, 1, 16'd3, "R4");
    do_ref(16'd1, 1, 0, 0, 0, "R4");
    do_ref(16'd5, 0, 2, 1, 16'd4, "R4");
    do_ref(16'd6, 0, 2, 1, 16'd5, "R4");
  endtask

  task automatic t_random();
    do_reset();
    policy = 2'd3;
    for (int i = 0; i < NF; i++) begin
      do_ref(PW'(10 * (i + 1)), 0, i, 0, 0, "R6");
      m_tag[i] = PW'(10 * (i + 1));
    end
    for (int k = 0; k < 6; k++) begin
      int vf;
      logic [PW-1:0] np;
      vf = int'(m_lfsr % 16'(NF));
      np = PW'(100 + k);
      do_ref(np, 0, vf, 1, m_tag[vf], "R6");
      m_tag[vf] = np;
    end
  endtask

  task automatic t_clear();
    do_reset();
    policy = 2'd0;
    do_ref(16'd7, 0, 0, 0, 0, "R8");
    do_ref(16'd8, 0, 1, 0, 0, "R8");
    check_counts(2, 0, 2, "R8");
    @(negedge clk);
    cnt_clr = 1'b1; ref_valid = 1'b1; ref_page = 16'd9;  // clear wins over this reference's count
    @(negedge clk);
    cnt_clr = 1'b0; ref_valid = 1'b0;
    m_lfsr = model_step(m_lfsr);
    check_counts(0, 0, 0, "R8");
    do_ref(16'd7, 1, 0, 0, 0, "R8");   // frames kept across the clear
    check_counts(1, 1, 0, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_canonical(2'd0, "R3");
    t_canonical(2'd2, "R5");
    t_fifo_hit();
    t_lru_hit();
    t_lifo();
    t_random();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule